// File: doc/BRIEF.md
# Peripheral Bridge Access Gate

This block stands on the path from a system bus to a bank of peripheral slots. Every request carries a master number, a slot number, a direction flag, a privilege attribute bit, an address and write data. The gate looks up the issuing master's rights and the target slot's protection settings. It then either passes the request to the peripheral side with a one-cycle strobe, or closes it with an error response so that the peripheral never sees a cycle.

The gate also sets the supervisor signal it sends to the peripheral side. A master that does not hold the privilege-level right always reaches the peripherals in user mode, whatever privilege bit it presents. Software programs the master rights and the slot protection through a small register port with word-wide writes and a combinational read-back. Each master and each slot owns a 4-bit field, and eight fields are packed into each 32-bit register.

Top module: `periph_access_gate`

## Requirements
- R1: After reset every field reads 0, `rsp_valid` and `per_strobe` are low, and every request is forwarded with `per_super` equal to 0.
- R2: Each accepted request (`req_valid` high at a rising edge) produces exactly one response one cycle later, with `rsp_valid` high on that cycle. With no request, `rsp_valid` and `per_strobe` stay low.
- R3: When a slot's trust-check bit (bit 0) is set, a read from a master without its read-trust right (bit 0) is denied, and a write from a master without its write-trust right (bit 1) is denied.
- R4: When a slot's write-lock bit (bit 1) is set, every write to it is denied and reads are unaffected.
- R5: `per_super` on a forwarded request equals `req_priv` when the master's privilege-level right (bit 2) is set, and is 0 otherwise.
- R6: When a slot's supervisor-only bit (bit 2) is set, a request is allowed only if `req_priv` is 1 and the master holds the privilege-level right.
- R7: A denied request gives `rsp_err` high with `per_strobe` low. An allowed request gives `per_strobe` high with `rsp_err` low.
- R8: A slot's posted-write bit (bit 3) is stored and read back, but it never changes whether a request is allowed.
- R9: A register write changes the decision only for requests accepted at later edges. A request accepted at the same edge as the write is judged on the old settings.
- R10: Register 0 holds masters 0 to 7, register 1 holds slots 0 to 7 and register 2 holds slots 8 to 15. Entry n sits at bits [4n+3:4n]. Bit 3 of a master field reads 0. Register 3 ignores writes and reads 0.
- R11: A forwarded request presents its slot number, direction, address and write data on `per_sel`, `per_write`, `per_addr` and `per_wdata` in the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write enable |
| cfg_waddr | input | 2 | Register index for writes |
| cfg_wdata | input | 32 | Register write data |
| cfg_raddr | input | 2 | Register index for read-back |
| cfg_rdata | output | 32 | Read-back data (combinational) |
| req_valid | input | 1 | Request present this cycle |
| req_master | input | 3 | Issuing master number |
| req_periph | input | 4 | Target slot number |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | Incoming privilege attribute |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Request write data |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Response is an error |
| per_strobe | output | 1 | Peripheral cycle start |
| per_sel | output | 4 | Selected slot |
| per_write | output | 1 | Peripheral direction |
| per_super | output | 1 | Effective supervisor signal |
| per_addr | output | ADDR_W | Peripheral address |
| per_wdata | output | DATA_W | Peripheral write data |

## Verification
Requests are run against masters that hold no rights, only read trust, only privilege level, or all rights. Each protection bit is set on its own slot, so every denial can be traced to one cause. The read/write pair on the trust-checked slot separates the read-trust and write-trust lookups. Privileged and unprivileged requests from masters with and without the privilege-level right separate the supervisor-only check from the forcing of `per_super`. A register write issued at the same edge as a request to the affected slot separates old-setting and new-setting timing. Distinct addresses and data on each request catch field swaps on the peripheral side.

// File: rtl/gate_pkg.sv
package gate_pkg;
    localparam int NUM_MASTERS    = 8;
    localparam int NUM_PERIPH     = 16;
    localparam int FIELD_W        = 4;
    localparam int CFG_DW         = 32;
    localparam int FIELDS_PER_REG = CFG_DW / FIELD_W;
    localparam int MST_REGS       = (NUM_MASTERS + FIELDS_PER_REG - 1) / FIELDS_PER_REG;
    localparam int PER_REGS       = (NUM_PERIPH + FIELDS_PER_REG - 1) / FIELDS_PER_REG;
    localparam int NUM_REGS       = MST_REGS + PER_REGS;
    localparam int CFG_AW         = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam int MST_W          = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;
    localparam int PER_W          = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1;

    // master rights: bit0 read trust, bit1 write trust, bit2 privilege level
    typedef struct packed {
        logic mpl;
        logic tw;
        logic tr;
    } mst_rights_t;

    // slot protection: bit0 trust check, bit1 write lock, bit2 supervisor only, bit3 posted write
    typedef struct packed {
        logic bw;
        logic sp;
        logic wp;
        logic tp;
    } per_ctl_t;
endpackage

// File: rtl/gate_cfg_regs.sv
module gate_cfg_regs
    import gate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CFG_AW-1:0] wr_idx,
    input  logic [CFG_DW-1:0] wr_data,
    input  logic [CFG_AW-1:0] rd_idx,
    output logic [CFG_DW-1:0] rd_data,
    input  logic [MST_W-1:0]  mst_sel,
    input  logic [PER_W-1:0]  per_sel,
    output mst_rights_t       mst_out,
    output per_ctl_t          per_out
);
    typedef struct packed {
        mst_rights_t [NUM_MASTERS-1:0] mst;
        per_ctl_t    [NUM_PERIPH-1:0]  per;
    } cfg_t;

    cfg_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            for (int m = 0; m < NUM_MASTERS; m++) begin
                if (wr_idx == CFG_AW'(m / FIELDS_PER_REG))
                    state_d.mst[m] = mst_rights_t'(wr_data[(m % FIELDS_PER_REG)*FIELD_W +: 3]);
            end
            for (int p = 0; p < NUM_PERIPH; p++) begin
                if (wr_idx == CFG_AW'(MST_REGS + p / FIELDS_PER_REG))
                    state_d.per[p] = per_ctl_t'(wr_data[(p % FIELDS_PER_REG)*FIELD_W +: 4]);
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int m = 0; m < NUM_MASTERS; m++) begin
            if (rd_idx == CFG_AW'(m / FIELDS_PER_REG))
                rd_data[(m % FIELDS_PER_REG)*FIELD_W +: FIELD_W] = FIELD_W'(state_q.mst[m]);
        end
        for (int p = 0; p < NUM_PERIPH; p++) begin
            if (rd_idx == CFG_AW'(MST_REGS + p / FIELDS_PER_REG))
                rd_data[(p % FIELDS_PER_REG)*FIELD_W +: FIELD_W] = FIELD_W'(state_q.per[p]);
        end
    end

    assign mst_out = state_q.mst[mst_sel];
    assign per_out = state_q.per[per_sel];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/gate_decide.sv
module gate_decide
    import gate_pkg::*;
(
    input  mst_rights_t rights,
    input  per_ctl_t    ctl,
    input  logic        is_write,
    input  logic        priv,
    output logic        grant,
    output logic        super_eff
);
    logic trusted;
    logic tp_fail;
    logic wp_fail;
    logic sp_fail;

    always_comb begin
        trusted   = is_write ? rights.tw : rights.tr;
        super_eff = priv & rights.mpl;
        tp_fail   = ctl.tp & ~trusted;
        wp_fail   = ctl.wp & is_write;
        sp_fail   = ctl.sp & ~super_eff;
        grant     = ~(tp_fail | wp_fail | sp_fail);
    end
endmodule

// File: rtl/periph_access_gate.sv
module periph_access_gate
    import gate_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_waddr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    input  logic [CFG_AW-1:0] cfg_raddr,
    output logic [CFG_DW-1:0] cfg_rdata,
    input  logic              req_valid,
    input  logic [MST_W-1:0]  req_master,
    input  logic [PER_W-1:0]  req_periph,
    input  logic              req_write,
    input  logic              req_priv,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic              per_strobe,
    output logic [PER_W-1:0]  per_sel,
    output logic              per_write,
    output logic              per_super,
    output logic [ADDR_W-1:0] per_addr,
    output logic [DATA_W-1:0] per_wdata
);
    typedef struct packed {
        logic              rsp_valid;
        logic              rsp_err;
        logic              strobe;
        logic [PER_W-1:0]  sel;
        logic              write;
        logic              super_;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } out_t;

    out_t        out_d, out_q;
    mst_rights_t cur_mst;
    per_ctl_t    cur_per;
    logic        grant;
    logic        super_eff;

    gate_cfg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_waddr),
        .wr_data (cfg_wdata),
        .rd_idx  (cfg_raddr),
        .rd_data (cfg_rdata),
        .mst_sel (req_master),
        .per_sel (req_periph),
        .mst_out (cur_mst),
        .per_out (cur_per)
    );

    gate_decide u_decide (
        .rights    (cur_mst),
        .ctl       (cur_per),
        .is_write  (req_write),
        .priv      (req_priv),
        .grant     (grant),
        .super_eff (super_eff)
    );

    always_comb begin
        out_d           = out_q;
        out_d.rsp_valid = req_valid;
        out_d.rsp_err   = req_valid & ~grant;
        out_d.strobe    = req_valid & grant;
        if (req_valid && grant) begin
            out_d.sel    = req_periph;
            out_d.write  = req_write;
            out_d.super_ = super_eff;
            out_d.addr   = req_addr;
            out_d.wdata  = req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rsp_valid  = out_q.rsp_valid;
    assign rsp_err    = out_q.rsp_err;
    assign per_strobe = out_q.strobe;
    assign per_sel    = out_q.sel;
    assign per_write  = out_q.write;
    assign per_super  = out_q.super_;
    assign per_addr   = out_q.addr;
    assign per_wdata  = out_q.wdata;
endmodule

// File: rtl/gate_checker.sv
module gate_checker
    import gate_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic        req_priv,
    input mst_rights_t cur_mst,
    input per_ctl_t    cur_per,
    input logic        rsp_valid,
    input logic        rsp_err,
    input logic        per_strobe,
    input logic        per_super
);
    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !per_strobe)); // R2
    AST_STROBE_XOR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (per_strobe != rsp_err)); // R7
    AST_TRUST_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && cur_per.tp && !cur_mst.tr) |=> rsp_err); // R3
    AST_TRUST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && cur_per.tp && !cur_mst.tw) |=> rsp_err); // R3
    AST_WRITE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && cur_per.wp) |=> rsp_err); // R4
    AST_USER_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cur_mst.mpl) |=> (!per_strobe || !per_super)); // R5
    AST_SUPER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cur_per.sp && !(req_priv && cur_mst.mpl)) |=> rsp_err); // R6
    AST_POSTED_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cur_per.tp && !cur_per.wp && !cur_per.sp) |=> per_strobe); // R8
endmodule

bind periph_access_gate gate_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_priv   (req_priv),
    .cur_mst    (cur_mst),
    .cur_per    (cur_per),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .per_strobe (per_strobe),
    .per_super  (per_super)
);

// File: tb/periph_access_gate_test.sv
module periph_access_gate_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        cfg_we = 0;
    logic [1:0]  cfg_waddr = 0;
    logic [31:0] cfg_wdata = 0;
    logic [1:0]  cfg_raddr = 0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 0;
    logic [2:0]  req_master = 0;
    logic [3:0]  req_periph = 0;
    logic        req_write = 0;
    logic        req_priv = 0;
    logic [15:0] req_addr = 0;
    logic [31:0] req_wdata = 0;
    logic        rsp_valid, rsp_err, per_strobe, per_write, per_super;
    logic [3:0]  per_sel;
    logic [15:0] per_addr;
    logic [31:0] per_wdata;

    int total = 0;
    int fails = 0;

    typedef struct {
        logic        err;
        logic        sup;
        logic [3:0]  sel;
        logic        wr;
        logic [15:0] addr;
        logic [31:0] wdata;
        string       tag;
    } exp_t;
    exp_t q[$];

    logic [3:0] mf[8];
    logic [3:0] pf[16];

    always #5 clk = ~clk;

    periph_access_gate uut (.*);

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(bit do_cfg, int ci, logic [31:0] cd, bit do_req, int m, int p,
                        bit w, bit pr, logic [15:0] a, logic [31:0] wd, string tag);
        exp_t e;
        bit   trusted, deny;
        @(negedge clk);
        if (do_req) begin
            trusted = w ? mf[m][1] : mf[m][0];
            deny = (pf[p][0] && !trusted) || (pf[p][1] && w) || (pf[p][2] && !(pr && mf[m][2]));
            e.err = deny; e.sup = pr & mf[m][2]; e.sel = 4'(p); e.wr = w;
            e.addr = a; e.wdata = wd; e.tag = tag;
            q.push_back(e);
        end
        req_valid = do_req; req_master = 3'(m); req_periph = 4'(p);
        req_write = w; req_priv = pr; req_addr = a; req_wdata = wd;
        cfg_we = do_cfg; cfg_waddr = 2'(ci); cfg_wdata = cd;
        if (do_cfg) begin
            for (int i = 0; i < 8; i++) begin
                if (ci == 0) mf[i] = cd[4*i +: 4];
                if (ci == 1) pf[i] = cd[4*i +: 4];
                if (ci == 2) pf[8+i] = cd[4*i +: 4];
            end
        end
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    endtask

    task automatic rb(int idx, logic [31:0] exp, string tag);
        @(negedge clk);
        cfg_raddr = 2'(idx);
        #1;
        check(cfg_rdata === exp, tag, "readback", cfg_rdata, exp);
    endtask

    // monitor: compare each response against the front of the scoreboard
    initial begin
        exp_t e;
        bit   ok;
        forever begin
            @(negedge clk);
            if (rst_n && rsp_valid) begin
                if (q.size() == 0) begin
                    check(0, "R2", "unexpected response", 32'(rsp_err), 0);
                end else begin
                    e = q.pop_front();
                    // R7 decision, R5 supervisor, R11 forwarded fields
                    ok = (rsp_err === e.err) && (per_strobe === !e.err);
                    if (!e.err)
                        ok = ok && per_sel === e.sel && per_write === e.wr && per_super === e.sup
                             && per_addr === e.addr && per_wdata === e.wdata;
                    check(ok, e.tag, "response {err,strobe,super,sel,addr}",
                          {rsp_err, per_strobe, per_super, per_sel, per_addr, 9'd0},
                          {e.err, !e.err, e.sup, e.sel, e.addr, 9'd0});
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(0, "watchdog", "timeout", 0, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) mf[i] = 0;
        for (int i = 0; i < 16; i++) pf[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        #1;
        check(!rsp_valid && !per_strobe, "R1", "outputs after reset", {rsp_valid, per_strobe}, 0);
        rb(0, 0, "R1"); rb(1, 0, "R1"); rb(2, 0, "R1");
        step(0, 0, 0, 1, 0, 0, 0, 1, 16'h0100, 32'h11, "R1");
        step(1, 0, 32'h0000_471F, 0, 0, 0, 0, 0, 0, 0, "");
        step(1, 1, 32'h0000_8421, 0, 0, 0, 0, 0, 0, 0, "");
        step(1, 2, 32'h0000_000F, 0, 0, 0, 0, 0, 0, 0, "");
        step(1, 3, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, 0, "");
        idle();
        rb(0, 32'h0000_4717, "R10");
        rb(1, 32'h0000_8421, "R8");
        rb(2, 32'h0000_000F, "R10");
        rb(3, 32'h0, "R10");
        // R3 trust check on slot 0
        step(0, 0, 0, 1, 1, 0, 0, 0, 16'h0200, 32'h21, "R3");
        step(0, 0, 0, 1, 1, 0, 1, 0, 16'h0204, 32'h22, "R3");
        step(0, 0, 0, 1, 2, 0, 1, 0, 16'h0208, 32'h23, "R3");
        step(0, 0, 0, 1, 3, 0, 0, 1, 16'h020C, 32'h24, "R3");
        // R4 write lock on slot 1
        step(0, 0, 0, 1, 2, 1, 1, 1, 16'h0300, 32'h31, "R4");
        step(0, 0, 0, 1, 2, 1, 0, 1, 16'h0304, 32'h32, "R4");
        // R6 supervisor-only slot 2
        step(0, 0, 0, 1, 2, 2, 0, 1, 16'h0400, 32'h41, "R6");
        step(0, 0, 0, 1, 2, 2, 0, 0, 16'h0404, 32'h42, "R6");
        step(0, 0, 0, 1, 1, 2, 0, 1, 16'h0408, 32'h43, "R6");
        step(0, 0, 0, 1, 3, 2, 1, 1, 16'h040C, 32'h44, "R6");
        // R5 supervisor forcing on open slot 4
        step(0, 0, 0, 1, 3, 4, 1, 1, 16'h0500, 32'h51, "R5");
        step(0, 0, 0, 1, 1, 4, 1, 1, 16'h0504, 32'h52, "R5");
        step(0, 0, 0, 1, 2, 4, 0, 0, 16'h0508, 32'h53, "R5");
        // R8 posted-write bit on slot 3 does not block
        step(0, 0, 0, 1, 1, 3, 1, 0, 16'h0600, 32'h61, "R8");
        // R7 all protections on slot 8
        step(0, 0, 0, 1, 2, 8, 1, 1, 16'h0700, 32'h71, "R7");
        // R9 write lock on slot 0 in the same cycle as a write to it
        step(1, 1, 32'h0000_8423, 1, 2, 0, 1, 0, 16'h0800, 32'h81, "R9");
        step(0, 0, 0, 1, 2, 0, 1, 0, 16'h0804, 32'h82, "R9");
        // R11 forwarded fields on the top slot
        step(0, 0, 0, 1, 0, 15, 1, 1, 16'hBEEF, 32'h1234_5678, "R11");
        idle();
        repeat (3) @(negedge clk);
        check(q.size() == 0, "R2", "responses outstanding", 32'(q.size()), 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule